// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a simple register bus and a one-time-programmable fuse store of 16 banks of 8 words, 32 bits each; the store is modelled inside the block as a register array. Software selects a fuse word through the control register and reads it with a sense operation. To burn bits into the word, software first loads an unlock key into the control register and then writes the program data register. Each operation runs through a fixed sequence of timed phases whose lengths, in clock cycles, come from the timing register. A busy flag covers the whole sequence. A sticky error flag records any attempt that was refused.

The sequencer has four states. IDLE moves to RELAX_PRE when an operation is accepted. RELAX_PRE moves to STROBE when its relax count runs out. STROBE moves to RELAX_POST when its strobe count runs out, and the sense capture or the program write happens on that transition. RELAX_POST moves back to IDLE when its second relax count runs out, and that is the cycle in which busy falls. The bus uses word offsets: 0 is the control register, 1 is the set alias, 2 is the clear alias, 3 is timing, 4 is read-control, 5 is program data and 6 is sensed data. Offset 7 reads as zero. Register reads are combinational.

Top module: `otp_ctl`

## Requirements
- R1: After reset the control, timing and sensed-data registers read 0, and busy is low.
- R2: Control bits 6:0 select fuse word bank*8+word. All 128 words are distinct: programming one word leaves a neighbouring address reading 0.
- R3: A write of a value with bit 0 set to read-control (offset 4) starts a sense. When busy falls, the sensed-data register (offset 6, also on port sense_data) holds the addressed word.
- R4: Busy stays high for (relax+1)+(strobe+1)+(relax+1) cycles. Relax is timing bits 15:12. The strobe count is timing bits 21:16 for a sense and bits 11:0 for a program.
- R5: A write to program data (offset 5) starts a program only while control bits 31:16 hold 0x3E77.
- R6: Programming ORs the data into the stored word, so a bit once set stays set.
- R7: Once a program completes, control bits 31:16 read 0.
- R8: A program write without the correct key starts nothing, leaves the fuse word unchanged and sets the error flag (control bit 9).
- R9: A start write (read-control bit 0, or program data) issued while busy is ignored and sets the error flag. The running operation finishes with its own result and duration.
- R10: The error flag is sticky. Only writing 1 to bit 9 through the clear alias (offset 2) clears it.
- R11: The set alias ORs and the clear alias AND-NOTs into the key, error and address fields. A plain control write replaces key and address and keeps the error flag. Neither alias can change the busy bit.
- R12: Busy is visible both as control bit 8 and on the busy port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| busy | output | 1 | Operation in progress |
| sense_data | output | 32 | Sensed-data register |

## Verification
The hardest condition to reach is a second start request that arrives while an operation is still in one of its timed phases. If that request slipped through, the sensed result or the phase lengths would be corrupted. The bench programs a relax count long enough to hold busy for many cycles. It then issues a second read-control write on the very next bus cycle after the first. The scoreboard still expects the first operation's exact duration and data, and a control read confirms the error flag. Alias writes to the busy bit are also issued while an operation is running, to show that they cannot end it early.

// File: rtl/otp_ctl_pkg.sv
package otp_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RELAX_PRE,
        ST_STROBE,
        ST_RELAX_POST
    } otp_state_e;

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_SET    = 3'd1;
    localparam logic [2:0] OFS_CLR    = 3'd2;
    localparam logic [2:0] OFS_TIMING = 3'd3;
    localparam logic [2:0] OFS_RDCTL  = 3'd4;
    localparam logic [2:0] OFS_PDATA  = 3'd5;
    localparam logic [2:0] OFS_RDATA  = 3'd6;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam int ERR_BIT  = 9;
    localparam int BUSY_BIT = 8;
    localparam int TRD_W = 6;
    localparam int TRX_W = 4;
    localparam int TPG_W = 12;
endpackage

// File: rtl/otp_seq.sv
module otp_seq
    import otp_ctl_pkg::*;
#(
    parameter int RX_W = 4,
    parameter int RD_W = 6,
    parameter int PG_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_prog,
    input  logic [RX_W-1:0] relax,
    input  logic [RD_W-1:0] strb_rd,
    input  logic [PG_W-1:0] strb_pg,
    output logic            busy,
    output logic            op_prog,
    output logic            strobe_end,
    output logic            op_end
);
    localparam int CW = (PG_W > RD_W) ? ((PG_W > RX_W) ? PG_W : RX_W)
                                      : ((RD_W > RX_W) ? RD_W : RX_W);

    otp_state_e state, nxt;
    logic [CW-1:0] cnt, nxt_cnt;

    always_comb begin
        nxt        = state;
        nxt_cnt    = cnt;
        strobe_end = 1'b0;
        op_end     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt     = ST_RELAX_PRE;
                    nxt_cnt = CW'(relax);
                end
            end
            ST_RELAX_PRE: begin
                if (cnt == '0) begin
                    nxt     = ST_STROBE;
                    nxt_cnt = op_prog ? CW'(strb_pg) : CW'(strb_rd);
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    nxt        = ST_RELAX_POST;
                    nxt_cnt    = CW'(relax);
                    strobe_end = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_RELAX_POST: begin
                if (cnt == '0) begin
                    nxt    = ST_IDLE;
                    op_end = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            op_prog <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
            if (state == ST_IDLE && start)
                op_prog <= start_prog;
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burn,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (burn) begin
            cells[addr] <= cells[addr] | wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/otp_ctl.sv
module otp_ctl
    import otp_ctl_pkg::*;
#(
    parameter int BANKS = 16,
    parameter int WPB   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy,
    output logic [31:0] sense_data
);
    localparam int WORDS = BANKS * WPB;
    localparam int AW    = $clog2(WORDS);

    logic [15:0]      ctrl_key;
    logic             ctrl_err;
    logic [AW-1:0]    ctrl_addr;
    logic [TRD_W-1:0] tim_rd;
    logic [TRX_W-1:0] tim_rx;
    logic [TPG_W-1:0] tim_pg;
    logic [31:0]      rd_data;
    logic [AW-1:0]    op_addr;
    logic [31:0]      op_wdata;

    logic wr, req_sense, req_prog, accept, reject, key_ok;
    logic seq_prog, strobe_end, op_end;
    logic [31:0] arr_q, ctrl_view;

    assign wr        = bus_sel && bus_wr;
    assign req_sense = wr && bus_addr == OFS_RDCTL && bus_wdata[0];
    assign req_prog  = wr && bus_addr == OFS_PDATA;
    assign key_ok    = (ctrl_key == UNLOCK_KEY);
    assign accept    = !busy && (req_sense || (req_prog && key_ok));
    assign reject    = (req_sense || req_prog) && !accept;

    otp_seq #(.RX_W(TRX_W), .RD_W(TRD_W), .PG_W(TPG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .start_prog(req_prog),
        .relax(tim_rx), .strb_rd(tim_rd), .strb_pg(tim_pg),
        .busy(busy), .op_prog(seq_prog), .strobe_end(strobe_end), .op_end(op_end)
    );

    otp_array #(.WORDS(WORDS), .DW(32)) u_arr (
        .clk(clk), .rst_n(rst_n), .burn(strobe_end && seq_prog),
        .addr(op_addr), .wdata(op_wdata), .rdata(arr_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_key  <= '0;
            ctrl_err  <= 1'b0;
            ctrl_addr <= '0;
            tim_rd    <= '0;
            tim_rx    <= '0;
            tim_pg    <= '0;
        end else begin
            if (wr) begin
                unique case (bus_addr)
                    OFS_CTRL: begin
                        ctrl_key  <= bus_wdata[31:16];
                        ctrl_addr <= bus_wdata[AW-1:0];
                    end
                    OFS_SET: begin
                        ctrl_key  <= ctrl_key | bus_wdata[31:16];
                        ctrl_addr <= ctrl_addr | bus_wdata[AW-1:0];
                        ctrl_err  <= ctrl_err | bus_wdata[ERR_BIT];
                    end
                    OFS_CLR: begin
                        ctrl_key  <= ctrl_key & ~bus_wdata[31:16];
                        ctrl_addr <= ctrl_addr & ~bus_wdata[AW-1:0];
                        ctrl_err  <= ctrl_err & ~bus_wdata[ERR_BIT];
                    end
                    OFS_TIMING: begin
                        tim_rd <= bus_wdata[16 +: TRD_W];
                        tim_rx <= bus_wdata[12 +: TRX_W];
                        tim_pg <= bus_wdata[0 +: TPG_W];
                    end
                    default: ;
                endcase
            end
            if (reject)
                ctrl_err <= 1'b1;
            if (op_end && seq_prog)
                ctrl_key <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_wdata <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                op_addr  <= ctrl_addr;
                op_wdata <= bus_wdata;
            end
            if (strobe_end && !seq_prog)
                rd_data <= arr_q;
        end
    end

    always_comb begin
        ctrl_view           = '0;
        ctrl_view[31:16]    = ctrl_key;
        ctrl_view[ERR_BIT]  = ctrl_err;
        ctrl_view[BUSY_BIT] = busy;
        ctrl_view[AW-1:0]   = ctrl_addr;
        unique case (bus_addr)
            OFS_CTRL, OFS_SET, OFS_CLR: bus_rdata = ctrl_view;
            OFS_TIMING: bus_rdata = {10'd0, tim_rd, tim_rx, tim_pg};
            OFS_RDATA:  bus_rdata = rd_data;
            default:    bus_rdata = '0;
        endcase
    end

    assign sense_data = rd_data;
endmodule

// File: rtl/otp_ctl_chk.sv
module otp_ctl_chk
    import otp_ctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic [15:0] key,
    input logic        err,
    input logic        op_prog
);
    logic wr_rdctl, wr_pdata, wr_clr_err;
    assign wr_rdctl   = bus_sel && bus_wr && bus_addr == OFS_RDCTL && bus_wdata[0];
    assign wr_pdata   = bus_sel && bus_wr && bus_addr == OFS_PDATA;
    assign wr_clr_err = bus_sel && bus_wr && bus_addr == OFS_CLR && bus_wdata[ERR_BIT];

    AST_SENSE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && wr_rdctl |=> busy); // R3

    AST_BAD_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && wr_pdata && key != UNLOCK_KEY |=> err && !busy); // R8

    AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (wr_rdctl || wr_pdata) |=> err); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !wr_clr_err |=> err); // R10

    AST_KEY_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(op_prog) |-> key == 16'h0); // R7
endmodule

bind otp_ctl otp_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .key(ctrl_key), .err(ctrl_err), .op_prog(seq_prog)
);

// File: tb/otp_ctl_test.sv
module otp_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        busy;
    logic [31:0] sense_data;

    otp_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .sense_data(sense_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          is_sense;
        logic [31:0] data;
        int          cycles;
    } item_t;

    item_t       sb[$];
    logic [31:0] model [128];
    int total = 0;
    int bad = 0;
    int t_rd = 0, t_rx = 0, t_pg = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_timing(input int rd, input int rx, input int pg);
        t_rd = rd; t_rx = rx; t_pg = pg;
        bus_write(3'd3, (32'(rd) << 16) | (32'(rx) << 12) | 32'(pg));
    endtask

    task automatic do_sense(input int a);
        item_t it;
        bus_write(3'd0, 32'(a));
        it.is_sense = 1; it.data = model[a]; it.cycles = 2 * t_rx + t_rd + 3;
        sb.push_back(it);
        bus_write(3'd4, 32'd1);
        wait_idle();
    endtask

    task automatic do_prog(input int a, input logic [31:0] d);
        item_t it;
        bus_write(3'd0, {16'h3E77, 16'(a)});
        it.is_sense = 0; it.data = 0; it.cycles = 2 * t_rx + t_pg + 3;
        sb.push_back(it);
        model[a] = model[a] | d;
        bus_write(3'd5, d);
        wait_idle();
    endtask

    // Monitor: pops one scoreboard item each time busy falls
    int  run_len = 0;
    bit  prev_busy = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0; prev_busy = 0;
        end else begin
            if (busy) run_len++;
            if (prev_busy && !busy) begin
                if (sb.size() == 0) begin
                    check("R9 unexpected completion", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check("R4 busy length", 32'(run_len), 32'(it.cycles));
                    if (it.is_sense) check("R3 sensed word", sense_data, it.data);
                end
                run_len = 0;
            end
            prev_busy = busy;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [31:0] r;
        item_t it;
        for (int i = 0; i < 128; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd0, r); check("R1 ctrl", r, 32'd0);
        bus_read(3'd3, r); check("R1 timing", r, 32'd0);
        bus_read(3'd6, r); check("R1 rdata", r, 32'd0);
        check("R1 busy", 32'(busy), 32'd0);

        // R4 timing readback and sense of blank word
        set_timing(3, 2, 5);
        bus_read(3'd3, r); check("R4 timing fields", r, 32'h0003_2005);
        do_sense(5);

        // R5/R7 program with key, key self-clears
        do_prog(8'h15, 32'h0000_00F0);
        bus_read(3'd0, r); check("R7 key cleared", r, 32'h0000_0015);
        do_sense(8'h15);

        // R8 wrong key: ignored, error set
        bus_write(3'd0, {16'h3E76, 16'h0015});
        bus_write(3'd5, 32'h0000_000F);
        check("R8 no busy", 32'(busy), 32'd0);
        bus_read(3'd0, r); check("R8 error set", r, 32'h3E76_0215);
        do_sense(8'h15);
        // R10 sticky: plain write keeps error, clear alias clears it
        bus_read(3'd0, r); check("R10 error kept", r[9], 1'b1);
        bus_write(3'd2, 32'h0000_0200);
        bus_read(3'd0, r); check("R10 error cleared", r, 32'h0000_0015);

        // R6 OR semantics
        do_prog(8'h15, 32'h0000_000F);
        do_prog(8'h15, 32'h0000_0000);
        do_sense(8'h15);
        check("R6 model", model[8'h15], 32'h0000_00FF);

        // R9 start while busy
        bus_write(3'd0, 32'h0000_0015);
        it.is_sense = 1; it.data = 32'h0000_00FF; it.cycles = 2 * t_rx + t_rd + 3;
        sb.push_back(it);
        bus_write(3'd4, 32'd1);
        bus_write(3'd4, 32'd1);
        // R11 clear alias on busy bit while running
        bus_write(3'd2, 32'h0000_0100);
        check("R11 busy survives clear alias", 32'(busy), 32'd1);
        bus_read(3'd0, r); check("R12 busy in ctrl", r[8], 1'b1);
        wait_idle();
        bus_read(3'd0, r); check("R9 error set", r, 32'h0000_0215);
        bus_write(3'd2, 32'h0000_0200);

        // R11 set alias cannot raise busy; alias on key and address
        bus_write(3'd1, 32'h3E77_0100);
        check("R11 busy not set", 32'(busy), 32'd0);
        bus_write(3'd2, 32'h0000_007F);
        bus_read(3'd0, r); check("R11 aliases", r, 32'h3E77_0000);
        it.is_sense = 0; it.data = 0; it.cycles = 2 * t_rx + t_pg + 3;
        sb.push_back(it);
        model[0] = 32'hA5A5_0001;
        bus_write(3'd5, 32'hA5A5_0001);
        wait_idle();

        // R2 decode at top address, minimum timing, neighbour stays blank
        set_timing(0, 0, 0);
        do_prog(8'h7F, 32'h8000_0001);
        do_sense(8'h7F);
        do_sense(8'h7E);
        do_sense(0);
        bus_read(3'd6, r); check("R2 word 0 readback", r, 32'hA5A5_0001);

        // R3 read-control with bit 0 clear starts nothing
        bus_write(3'd4, 32'd0);
        check("R3 no start", 32'(busy), 32'd0);

        repeat (4) @(negedge clk);
        check("R4 scoreboard drained", 32'(sb.size()), 32'd0);
        report();
    end
endmodule